// File: doc/BRIEF.md
# Double-Buffered Output-Compare Timer Channels

This block holds a set of output-compare channels that watch a free-running time count. Each channel keeps an armed target value. When the count equals that target while the channel has a nonzero mode, the channel latches an event flag. It also changes its output pin according to the mode: one mode inverts the pin, another drives it high for exactly one clock. The flag can be routed to an interrupt line and to a DMA request line.

The target is buffered one deep. While a channel is idle (mode zero), a write to its compare register arms the target directly. While it is running, a write queues the following target, and that queued value takes over at the next match. Software can therefore stay one period ahead, so a once-per-second output keeps running without gaps. If nothing is queued when a match occurs, the channel keeps its target and fires again when the count comes round to it after a wrap.

Registers are reached through a plain single-cycle write port and a combinational read port that share one address. Channel n has its control/status register at byte address 0x608 + 8n and its compare register at 0x60C + 8n.

Top module: `cmp_timer_channels`

## Requirements
- R1: After reset every control/status register and every compare register reads 0, and all pins, interrupt lines and DMA request lines are low.
- R2: Control/status fields: bit 0 is the DMA-request enable, bits 5:2 are the mode, bit 6 is the interrupt enable and bit 7 is the event flag. Bit 1 and bits 31:8 read 0. The dma_req output of a channel is high exactly while its flag and its DMA enable are both set.
- R3: A channel whose mode is nonzero sets its flag at any clock edge where count equals its active target. A channel with mode 0 never matches.
- R4: Mode 0x5 inverts the channel pin at each match. The pin keeps its level between matches.
- R5: Mode 0xF drives the pin high for exactly the one clock that follows the matching edge.
- R6: Writing the control/status register with bit 7 set clears the flag, and writing it with bit 7 clear leaves the flag unchanged. A match on the same edge as a clear leaves the flag set.
- R7: The irq output of a channel is high exactly while its flag and its interrupt enable are both set.
- R8: A compare write while the mode is 0 arms the value at once, and it discards any queued value. A compare write while the mode is nonzero only queues the value, and the register keeps reading back the active target.
- R9: At a match, a queued value becomes the active target, and the compare register reads back that new value from the next cycle on.
- R10: With nothing queued, a match keeps the same target, and the channel fires again the next time the count equals it, for example after a wrap.
- R11: Writing 0 to the control/status register stops the channel: the pin goes low on that edge, no further match sets the flag, and a flag that was already set stays set until it is cleared.
- R12: Writes to addresses that map to no channel register change nothing and read back 0. The channels are independent of one another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the count advances in this domain |
| rst_n | input | 1 | Active-low synchronous reset |
| count | input | CW | Current value of the time count |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | AW | Byte address for both the write and the read |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Combinational read data for reg_addr |
| pin_out | output | NCH | Compare output pin of each channel |
| irq | output | NCH | Interrupt line of each channel |
| dma_req | output | NCH | DMA request line of each channel |

## Verification
The properties assume that the count presents a given value for a single clock at a time, so that a target counts as reached once per pass. They also assume that any register write may change a mode, which is why the toggle and target-holding properties are waived in write cycles. The stimulus drives the count to a match value for exactly one cycle and then parks it on an idle value that no target uses. It also avoids moving the count on a cycle in which a register is written.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  localparam logic [3:0] MODE_OFF    = 4'h0;
  localparam logic [3:0] MODE_TOGGLE = 4'h5;
  localparam logic [3:0] MODE_PULSE  = 4'hF;

  // control/status byte; field positions are decoded by software
  typedef struct packed {
    logic       flag;   // bit 7, write one to clear
    logic       ie;     // bit 6
    logic [3:0] mode;   // bits 5:2
    logic       rsv;    // bit 1, reads zero
    logic       dma_en; // bit 0
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);
endpackage

// File: rtl/cmp_compare_buf.sv
module cmp_compare_buf #(
  parameter int CW = 31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [CW-1:0] wdata,
  input  logic          armed,
  input  logic          hit,
  output logic [CW-1:0] active
);
  logic [CW-1:0] active_q;
  logic [CW-1:0] next_q;
  logic          next_vld;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= '0;
      next_q   <= '0;
      next_vld <= 1'b0;
    end else if (wr && !armed) begin
      // fresh arming: straight into the active slot, queue dropped
      active_q <= wdata;
      next_vld <= 1'b0;
    end else begin
      if (hit && next_vld) active_q <= next_q;
      if (wr) begin
        next_q   <= wdata;
        next_vld <= 1'b1;
      end else if (hit) begin
        next_vld <= 1'b0;
      end
    end
  end

  assign active = active_q;
endmodule

// File: rtl/cmp_channel.sv
module cmp_channel
  import cmp_pkg::*;
#(
  parameter int CW = 31,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count,
  input  logic          ctl_wr,
  input  logic          cmp_wr,
  input  logic [DW-1:0] wdata,
  output logic [CTL_W-1:0] ctl_rd,
  output logic [CW-1:0] active,
  output logic [3:0]    mode,
  output logic          flag,
  output logic          pin,
  output logic          irq,
  output logic          dma_req
);
  ctl_t ctl_q, ctl_n;
  logic pin_q, pin_n;
  logic armed, hit;
  logic [CW-1:0] tgt;

  assign armed = (ctl_q.mode != MODE_OFF);
  assign hit   = armed && (count == tgt);

  always_comb begin
    ctl_n = ctl_q;
    if (ctl_wr) begin
      ctl_n.dma_en = wdata[0];
      ctl_n.mode   = wdata[5:2];
      ctl_n.ie     = wdata[6];
      if (wdata[7]) ctl_n.flag = 1'b0;
    end
    ctl_n.rsv = 1'b0;
    if (hit) ctl_n.flag = 1'b1;
  end

  always_comb begin
    if (ctl_n.mode == MODE_OFF) begin
      pin_n = 1'b0;
    end else begin
      unique case (ctl_q.mode)
        MODE_TOGGLE: pin_n = pin_q ^ hit;
        MODE_PULSE:  pin_n = hit;
        default:     pin_n = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0;
      pin_q <= 1'b0;
    end else begin
      ctl_q <= ctl_n;
      pin_q <= pin_n;
    end
  end

  cmp_compare_buf #(.CW(CW)) u_buf (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (cmp_wr),
    .wdata  (wdata[CW-1:0]),
    .armed  (armed),
    .hit    (hit),
    .active (tgt)
  );

  assign ctl_rd  = ctl_q;
  assign active  = tgt;
  assign mode    = ctl_q.mode;
  assign flag    = ctl_q.flag;
  assign pin     = pin_q;
  assign irq     = ctl_q.flag & ctl_q.ie;
  assign dma_req = ctl_q.flag & ctl_q.dma_en;
endmodule

// File: rtl/cmp_regdec.sv
module cmp_regdec #(
  parameter int NCH    = 4,
  parameter int AW     = 12,
  parameter int BASE   = 'h608,
  parameter int STRIDE = 8
) (
  input  logic [AW-1:0]  addr,
  output logic [NCH-1:0] ctl_sel,
  output logic [NCH-1:0] cmp_sel
);
  for (genvar i = 0; i < NCH; i++) begin : g_dec
    localparam logic [AW-1:0] CTL_A = AW'(BASE + i * STRIDE);
    localparam logic [AW-1:0] CMP_A = AW'(BASE + i * STRIDE + 4);
    assign ctl_sel[i] = (addr == CTL_A);
    assign cmp_sel[i] = (addr == CMP_A);
  end
endmodule

// File: rtl/cmp_timer_channels.sv
module cmp_timer_channels
  import cmp_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int CW     = 31,
  parameter int AW     = 12,
  parameter int DW     = 32,
  parameter int BASE   = 'h608,
  parameter int STRIDE = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [CW-1:0]  count,
  input  logic           reg_wr,
  input  logic [AW-1:0]  reg_addr,
  input  logic [DW-1:0]  reg_wdata,
  output logic [DW-1:0]  reg_rdata,
  output logic [NCH-1:0] pin_out,
  output logic [NCH-1:0] irq,
  output logic [NCH-1:0] dma_req
);
  logic [NCH-1:0]       ctl_sel, cmp_sel;
  logic [NCH*CTL_W-1:0] ch_ctl;
  logic [NCH*CW-1:0]    ch_active;
  logic [NCH*4-1:0]     ch_mode;
  logic [NCH-1:0]       ch_flag;

  cmp_regdec #(.NCH(NCH), .AW(AW), .BASE(BASE), .STRIDE(STRIDE)) u_dec (
    .addr    (reg_addr),
    .ctl_sel (ctl_sel),
    .cmp_sel (cmp_sel)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    cmp_channel #(.CW(CW), .DW(DW)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .count   (count),
      .ctl_wr  (reg_wr && ctl_sel[i]),
      .cmp_wr  (reg_wr && cmp_sel[i]),
      .wdata   (reg_wdata),
      .ctl_rd  (ch_ctl[i*CTL_W +: CTL_W]),
      .active  (ch_active[i*CW +: CW]),
      .mode    (ch_mode[i*4 +: 4]),
      .flag    (ch_flag[i]),
      .pin     (pin_out[i]),
      .irq     (irq[i]),
      .dma_req (dma_req[i])
    );
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NCH; i++) begin
      if (ctl_sel[i]) reg_rdata = DW'(ch_ctl[i*CTL_W +: CTL_W]);
      if (cmp_sel[i]) reg_rdata = DW'(ch_active[i*CW +: CW]);
    end
  end
endmodule

// File: rtl/cmp_timer_channels_chk.sv
module cmp_timer_channels_chk #(
  parameter int NCH = 4,
  parameter int CW  = 31
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CW-1:0]     count,
  input logic              reg_wr,
  input logic [NCH-1:0]    pin_out,
  input logic [NCH*CW-1:0] ch_active,
  input logic [NCH*4-1:0]  ch_mode,
  input logic [NCH-1:0]    ch_flag
);
  for (genvar i = 0; i < NCH; i++) begin : g_prop
    AST_MATCH_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_mode[i*4 +: 4] != 4'h0 && count == ch_active[i*CW +: CW]) |=> ch_flag[i]); // R3
    AST_TOGGLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_mode[i*4 +: 4] == 4'h5 && count != ch_active[i*CW +: CW] && !reg_wr) |=> $stable(pin_out[i])); // R4
    AST_PULSE_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_mode[i*4 +: 4] == 4'hF && count != ch_active[i*CW +: CW]) |=> !pin_out[i]); // R5
    AST_TARGET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_wr && !(ch_mode[i*4 +: 4] != 4'h0 && count == ch_active[i*CW +: CW]))
        |=> $stable(ch_active[i*CW +: CW])); // R9
    AST_IDLE_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_mode[i*4 +: 4] == 4'h0) |=> !$rose(ch_flag[i])); // R11
  end
endmodule

bind cmp_timer_channels cmp_timer_channels_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .count     (count),
  .reg_wr    (reg_wr),
  .pin_out   (pin_out),
  .ch_active (ch_active),
  .ch_mode   (ch_mode),
  .ch_flag   (ch_flag)
);

// File: tb/cmp_timer_channels_test.sv
`timescale 1ns/1ps
module cmp_timer_channels_test;
  localparam int NCH = 4, CW = 31, AW = 12, DW = 32;
  localparam logic [CW-1:0] IDLE = CW'(100);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [CW-1:0] count = IDLE;
  logic reg_wr = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic [NCH-1:0] pin_out, irq, dma_req;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cmp_timer_channels uut (
    .clk(clk), .rst_n(rst_n), .count(count), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pin_out(pin_out), .irq(irq), .dma_req(dma_req)
  );

  function automatic logic [AW-1:0] ctl_a(int n); return AW'('h608 + 8*n); endfunction
  function automatic logic [AW-1:0] cmp_a(int n); return AW'('h60C + 8*n); endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [DW-1:0] d);
    reg_addr = a; #0.5; d = reg_rdata;
  endtask

  // count sits on v for one clock edge, then returns to idle
  task automatic hit(logic [CW-1:0] v);
    @(negedge clk); count = v;
    @(negedge clk); count = IDLE;
  endtask

  task automatic t_reset();
    logic [DW-1:0] d;
    for (int n = 0; n < NCH; n++) begin
      rd(ctl_a(n), d); chk("R1 ctl after reset", d, 0);
      rd(cmp_a(n), d); chk("R1 cmp after reset", d, 0);
    end
    chk("R1 pins", pin_out, 0);
    chk("R1 irq", irq, 0);
    chk("R1 dma", dma_req, 0);
  endtask

  task automatic t_toggle();
    logic [DW-1:0] d;
    wr(ctl_a(1), 32'h41);
    rd(ctl_a(1), d); chk("R2 field readback", d, 32'h41);
    wr(cmp_a(1), 32'd500);
    rd(cmp_a(1), d); chk("R8 idle write arms", d, 500);
    wr(ctl_a(1), 32'h55);
    hit(CW'(500));
    rd(ctl_a(1), d); chk("R3 flag on match", d, 32'hD5);
    chk("R7 irq", irq[1], 1);
    chk("R2 dma_req", dma_req[1], 1);
    chk("R4 toggle high", pin_out[1], 1);
    @(negedge clk); chk("R4 toggle holds", pin_out[1], 1);
    hit(CW'(500));
    chk("R10 same target fires again", pin_out[1], 0);
    wr(ctl_a(1), 32'h55);
    rd(ctl_a(1), d); chk("R6 zero bit keeps flag", d, 32'hD5);
    wr(ctl_a(1), 32'hD5);
    rd(ctl_a(1), d); chk("R6 w1c clears", d, 32'h55);
    chk("R7 irq low after clear", irq[1], 0);
    chk("R2 dma low after clear", dma_req[1], 0);
  endtask

  task automatic t_pulse_queue();
    logic [DW-1:0] d;
    wr(cmp_a(0), 32'd1000);
    wr(ctl_a(0), 32'h7C);
    wr(cmp_a(0), 32'd2000);
    rd(cmp_a(0), d); chk("R8 queued write hidden", d, 1000);
    hit(CW'(2000));
    chk("R3 no match on queued value", irq[0], 0);
    hit(CW'(1000));
    chk("R5 pulse high", pin_out[0], 1);
    rd(cmp_a(0), d); chk("R9 queue promoted", d, 2000);
    @(negedge clk); chk("R5 pulse one clock", pin_out[0], 0);
    wr(ctl_a(0), 32'hFC);
    chk("R6 cleared", irq[0], 0);
    hit(CW'(2000));
    chk("R9 fires at promoted target", irq[0], 1);
  endtask

  task automatic t_mode_off();
    logic [DW-1:0] d;
    wr(cmp_a(2), 32'd300);
    hit(CW'(300));
    rd(ctl_a(2), d); chk("R3 mode 0 no match", d, 0);
    chk("R3 mode 0 pin low", pin_out[2], 0);
  endtask

  task automatic t_wrap();
    logic [DW-1:0] d;
    wr(cmp_a(3), 32'h7FFF_FFFF);
    wr(ctl_a(3), 32'h7C);
    hit(CW'(32'h7FFF_FFFF));
    chk("R10 fires at top", irq[3], 1);
    wr(ctl_a(3), 32'hFC);
    hit(CW'(0));
    chk("R10 no fire at zero", irq[3], 0);
    hit(CW'(32'h7FFF_FFFF));
    chk("R10 fires after wrap", irq[3], 1);
    rd(cmp_a(3), d); chk("R10 target kept", d, 32'h7FFF_FFFF);
  endtask

  task automatic t_disable();
    logic [DW-1:0] d;
    hit(CW'(500));
    chk("R4 toggle again", pin_out[1], 1);
    wr(ctl_a(1), 32'h0);
    chk("R11 pin low on disable", pin_out[1], 0);
    rd(ctl_a(1), d); chk("R11 flag survives", d, 32'h80);
    hit(CW'(500));
    chk("R11 no pin after disable", pin_out[1], 0);
    wr(ctl_a(1), 32'h80);
    hit(CW'(500));
    rd(ctl_a(1), d); chk("R11 no new flag", d, 0);
  endtask

  task automatic t_fresh_arm();
    logic [DW-1:0] d;
    wr(ctl_a(0), 32'h7C);
    wr(cmp_a(0), 32'd900);
    wr(ctl_a(0), 32'h80);
    wr(cmp_a(0), 32'd700);
    wr(ctl_a(0), 32'h3C);
    hit(CW'(700));
    rd(ctl_a(0), d); chk("R8 rearm fires", d, 32'hBC);
    rd(cmp_a(0), d); chk("R8 stale queue dropped", d, 700);
  endtask

  task automatic t_addr();
    logic [DW-1:0] d;
    wr(AW'('h600), 32'hFF);
    wr(AW'('h628), 32'hFF);
    wr(AW'('h60A), 32'hFF);
    rd(AW'('h628), d); chk("R12 unmapped reads 0", d, 0);
    rd(ctl_a(2), d); chk("R12 ch2 untouched", d, 0);
    rd(ctl_a(1), d); chk("R12 ch1 untouched", d, 0);
    rd(cmp_a(2), d); chk("R12 ch2 target kept", d, 300);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_toggle();
    t_pulse_queue();
    t_mode_off();
    t_wrap();
    t_disable();
    t_fresh_arm();
    t_addr();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule